// File: doc/BRIEF.md
# I2S Master Transmit Serializer

This block drives the transmit side of an I2S link and is always the bus master. It runs on the audio master clock. From that clock it derives the bit clock through a programmable divider, and it generates the word-select line itself. It takes 32-bit sample words from a transmit FIFO over a valid/ready port, two words per frame: left first, then right. From each word it shifts out only the low bits, as many as the resolution setting gives, most significant bit first, in standard I2S timing.

Raising the transmit enable starts the link. Each start opens with one full frame of zero samples. Queued data follows that frame. If the FIFO is empty when a slot is due, that slot carries zeros and the framing carries on. Dropping the enable lets the current frame finish. The link then parks with all three bus lines low.

With the master clock at 256 times the sample rate, a ratio of 0 gives 64 bit clocks per frame, which suits 32-bit stereo. A ratio of 2 gives 32 bit clocks per frame, which suits 16-bit stereo.

Top module: `i2s_master_ser`

## Requirements
- R1: One bit-clock period is 2*(ratio+2) master-clock cycles, high and low for ratio+2 cycles each. The ratio is an unsigned 8-bit value captured when transmission starts.
- R2: Word select is low for the left slot and high for the right slot. It changes together with the last bit of the previous slot, so a slot's MSB appears one bit clock after the word-select edge. Serial data and word select change only on falling bit-clock edges, for sampling on rising edges.
- R3: A slot is N bits long, where N is the 6-bit resolution captured at start. A value of 0 or above 32 gives N=32, and a value of 1 gives N=2. Bits N-1 down to 0 of the word are sent MSB first, and the upper bits of the word are ignored.
- R4: Every start from idle sends one frame of zeros, left slot then right slot, before any FIFO word. No word is taken from the FIFO during that frame.
- R5: After the zero frame, each slot takes one FIFO word, left then right. fifo_ready_o is high for one cycle when a slot loads, and a word is consumed when fifo_valid_i and fifo_ready_o are both high. Words come out in FIFO order.
- R6: If fifo_valid_i is low when a slot loads, the slot carries all zeros and framing continues unchanged.
- R7: When tx_en_i is low at the end of a right slot, the frame ends there. bclk_o, ws_o and sd_o then stay low, no further words are taken, and every transmission holds a whole number of frames.
- R8: While rst is high and after it is released with tx_en_i low, bclk_o, ws_o, sd_o and fifo_ready_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en_i | input | 1 | Transmit enable |
| ratio_i | input | RATIO_W | Bit-clock divider setting |
| res_i | input | RES_W | Slot resolution in bits |
| fifo_data_i | input | WORD_W | FIFO head word |
| fifo_valid_i | input | 1 | FIFO holds a word |
| fifo_ready_o | output | 1 | Pop strobe for the FIFO head |
| bclk_o | output | 1 | I2S bit clock |
| ws_o | output | 1 | I2S word select |
| sd_o | output | 1 | I2S serial data |

## Verification
The bench builds the block with its default parameters: 32-bit words, an 8-bit ratio and a 6-bit resolution. Every slot width from 2 to 32 bits is therefore reachable, along with both clamping cases of the resolution field. Ratios are held to small values so that many full transmissions fit in the run time; the divider logic is the same at any ratio. A bench receiver decodes the bus on rising bit-clock edges and checks each slot's width, channel and value. Random word counts produce odd-length queues, which leave the FIFO empty partway through a frame.

// File: rtl/i2s_ser_pkg.sv
package i2s_ser_pkg;

    localparam int SER_WORD_W  = 32;
    localparam int SER_RATIO_W = 8;
    localparam int SER_RES_W   = 6;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Effective slot length for a requested resolution.
    function automatic int slot_len(int res, int word_w);
        if (res == 0 || res > word_w) return word_w;
        if (res < 2) return 2;
        return res;
    endfunction

endpackage

// File: rtl/i2s_bclk_div.sv
module i2s_bclk_div #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run_i,
    input  logic               start_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               bclk_o,
    output logic               fall_o
);
    localparam int CNT_W = RATIO_W + 1;

    logic [RATIO_W-1:0] ratio_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   half_m1;
    logic               bclk_q;

    // Half period is ratio+2 cycles; terminal count is ratio+1.
    assign half_m1 = {1'b0, ratio_q} + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q <= '0;
        end else if (start_i) begin
            ratio_q <= ratio_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q  <= '0;
            bclk_q <= 1'b0;
        end else if (cnt_q == half_m1) begin
            cnt_q  <= '0;
            bclk_q <= ~bclk_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign fall_o = run_i && bclk_q && (cnt_q == half_m1);
    assign bclk_o = bclk_q;

    // R1: counter never passes the terminal value while running
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (cnt_q <= half_m1));

    // R1: the bit clock only rises when the divider was running
    a_r1_rise_needs_run: assert property (@(posedge clk) disable iff (rst)
        $rose(bclk_q) |-> $past(run_i));

endmodule

// File: rtl/i2s_slot_seq.sv
module i2s_slot_seq
    import i2s_ser_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int RES_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en_i,
    input  logic [RES_W-1:0]  res_i,
    input  logic              fall_i,
    input  logic [WORD_W-1:0] fifo_data_i,
    input  logic              fifo_valid_i,
    output logic              fifo_ready_o,
    output logic              run_o,
    output logic              start_o,
    output logic              sd_o,
    output logic              ws_o
);
    localparam int PTR_W = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [PTR_W-1:0]  bitptr;
        logic              chan;   // 0 left, 1 right
        logic              zero;   // slot belongs to the opening zero frame
    } slot_t;

    seq_state_e        state_q;
    slot_t             slot_q;
    logic [RES_W-1:0]  len_q;
    logic [RES_W-1:0]  res_len;
    logic [PTR_W-1:0]  top_ptr;
    logic [WORD_W-1:0] mask_w;
    logic [WORD_W-1:0] new_word;
    logic              sd_q;
    logic              ws_q;
    logic              last_bit;
    logic              frame_end;
    logic              stop;
    logic              load;
    logic              next_zero;

    assign res_len   = RES_W'(slot_len(int'(res_i), WORD_W));
    assign top_ptr   = PTR_W'(len_q - 1'b1);
    assign mask_w    = {WORD_W{1'b1}} >> (WORD_W - int'(len_q));

    assign start_o   = (state_q == SEQ_IDLE) && tx_en_i;
    assign run_o     = (state_q == SEQ_RUN);
    assign last_bit  = (slot_q.bitptr == '0);
    assign frame_end = run_o && fall_i && last_bit && slot_q.chan;
    assign stop      = frame_end && !tx_en_i;
    assign load      = run_o && fall_i && last_bit && !stop;
    // The zero frame covers its right slot and ends at the frame boundary.
    assign next_zero = slot_q.zero && !slot_q.chan;

    assign fifo_ready_o = load && !next_zero;
    assign new_word     = (fifo_ready_o && fifo_valid_i) ? (fifo_data_i & mask_w) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            slot_q  <= '0;
            len_q   <= RES_W'(WORD_W);
            sd_q    <= 1'b0;
            ws_q    <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (tx_en_i) begin
                        state_q       <= SEQ_RUN;
                        len_q         <= res_len;
                        slot_q.word   <= '0;
                        slot_q.bitptr <= PTR_W'(res_len - 1'b1);
                        slot_q.chan   <= 1'b0;
                        slot_q.zero   <= 1'b1;
                        sd_q          <= 1'b0;
                        ws_q          <= 1'b0;
                    end
                end
                SEQ_RUN: begin
                    if (stop) begin
                        state_q     <= SEQ_IDLE;
                        slot_q.chan <= 1'b0;
                        slot_q.zero <= 1'b0;
                        sd_q        <= 1'b0;
                        ws_q        <= 1'b0;
                    end else if (load) begin
                        slot_q.word   <= new_word;
                        slot_q.bitptr <= top_ptr;
                        slot_q.chan   <= ~slot_q.chan;
                        slot_q.zero   <= next_zero;
                        sd_q          <= new_word[top_ptr];
                    end else if (fall_i) begin
                        slot_q.bitptr <= slot_q.bitptr - 1'b1;
                        sd_q          <= slot_q.word[slot_q.bitptr - 1'b1];
                        if (slot_q.bitptr == PTR_W'(1)) begin
                            ws_q <= ~slot_q.chan;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign sd_o = sd_q;
    assign ws_o = ws_q;

    // R7: parked link keeps both data lines low
    a_r7_idle_low: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_IDLE) |-> (!ws_q && !sd_q));

endmodule

// File: rtl/i2s_master_ser.sv
module i2s_master_ser
    import i2s_ser_pkg::*;
#(
    parameter int WORD_W  = SER_WORD_W,
    parameter int RATIO_W = SER_RATIO_W,
    parameter int RES_W   = SER_RES_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tx_en_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [RES_W-1:0]   res_i,
    input  logic [WORD_W-1:0]  fifo_data_i,
    input  logic               fifo_valid_i,
    output logic               fifo_ready_o,
    output logic               bclk_o,
    output logic               ws_o,
    output logic               sd_o
);
    logic run_w;
    logic start_w;
    logic fall_w;

    i2s_bclk_div #(
        .RATIO_W (RATIO_W)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .run_i   (run_w),
        .start_i (start_w),
        .ratio_i (ratio_i),
        .bclk_o  (bclk_o),
        .fall_o  (fall_w)
    );

    i2s_slot_seq #(
        .WORD_W (WORD_W),
        .RES_W  (RES_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .tx_en_i      (tx_en_i),
        .res_i        (res_i),
        .fall_i       (fall_w),
        .fifo_data_i  (fifo_data_i),
        .fifo_valid_i (fifo_valid_i),
        .fifo_ready_o (fifo_ready_o),
        .run_o        (run_w),
        .start_o      (start_w),
        .sd_o         (sd_o),
        .ws_o         (ws_o)
    );

    // R2: word select moves only with a falling bit clock
    a_r2_ws_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(ws_o) |-> $fell(bclk_o));

    // R2: serial data moves only with a falling bit clock
    a_r2_sd_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(sd_o) |-> $fell(bclk_o));

    // R5: a pop strobe coincides with a falling bit-clock edge
    a_r5_ready_on_fall: assert property (@(posedge clk) disable iff (rst)
        fifo_ready_o |=> $fell(bclk_o));

endmodule

// File: tb/i2s_master_ser_tb_top.sv
module i2s_master_ser_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 1'b0;
    logic [7:0]  ratio = '0;
    logic [5:0]  res = '0;
    logic [31:0] fifo_data;
    logic        fifo_valid;
    logic        fifo_ready;
    logic        bclk, ws, sd;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    // FIFO model
    logic [31:0] fq [0:255];
    int wr_p = 0;
    int rd_p = 0;
    assign fifo_valid = (rd_p < wr_p);
    assign fifo_data  = fq[rd_p[7:0]];
    always @(posedge clk) if (fifo_valid && fifo_ready) rd_p <= rd_p + 1;

    i2s_master_ser dut_i (
        .clk          (clk),
        .rst          (rst),
        .tx_en_i      (tx_en),
        .ratio_i      (ratio),
        .res_i        (res),
        .fifo_data_i  (fifo_data),
        .fifo_valid_i (fifo_valid),
        .fifo_ready_o (fifo_ready),
        .bclk_o       (bclk),
        .ws_o         (ws),
        .sd_o         (sd)
    );

    // Bus receiver
    logic        pb = 0, pws = 0, psd = 0, lws = 0;
    logic [31:0] sh = '0;
    int          bc = 0, gap = 0, rises = 0, exp_per = 4;
    int          per_err = 0, edge_err = 0, n_slots = 0;
    logic [31:0] gw [0:63];
    int          gl [0:63];
    logic        gc [0:63];

    always @(negedge clk) begin
        gap = gap + 1;
        if (!pb && bclk) begin
            if (rises > 0 && gap != exp_per) per_err = per_err + 1;
            rises = rises + 1;
            gap = 0;
            sh = {sh[30:0], sd};
            bc = bc + 1;
            if (ws != lws) begin
                if (n_slots < 64) begin
                    gw[n_slots] = sh; gl[n_slots] = bc; gc[n_slots] = lws;
                end
                n_slots = n_slots + 1;
                sh = '0;
                bc = 0;
            end
            lws = ws;
        end
        if ((sd != psd || ws != pws) && !(pb && !bclk)) edge_err = edge_err + 1;
        pb = bclk; pws = ws; psd = sd;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int eff_len(int r);
        if (r == 0 || r > 32) return 32;
        if (r < 2) return 2;
        return r;
    endfunction

    function automatic logic [31:0] lowmask(int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
    endfunction

    task automatic run_case(input int rt, input int rs, input int nw, input int tail);
        int n = eff_len(rs);
        int base = wr_p;
        int frames, cyc, quiet, exp_w, total;
        logic [31:0] m = lowmask(n);
        @(posedge clk);
        n_slots = 0; per_err = 0; edge_err = 0; rises = 0; sh = '0; bc = 0; lws = 0; gap = 0;
        exp_per = 2 * (rt + 2);
        ratio = 8'(rt);
        res = 6'(rs);
        for (int i = 0; i < nw; i++) begin
            fq[8'(wr_p)] = $urandom;
            wr_p = wr_p + 1;
        end
        tx_en = 1'b1;
        frames = 2 + (nw + 1) / 2 + tail;
        cyc = frames * 2 * n * exp_per;
        repeat (cyc) @(posedge clk);
        tx_en = 1'b0;
        quiet = 0;
        while (quiet < 64) begin
            @(negedge clk);
            quiet = bclk ? 0 : quiet + 1;
        end
        chk(n_slots % 2 == 0, "R7 whole frames", n_slots, n_slots + (n_slots % 2));
        chk(n_slots >= 2 + nw, "R5 slot count", n_slots, 2 + nw);
        chk(rd_p == wr_p, "R5 all words taken", rd_p, wr_p);
        chk(per_err == 0, "R1 bit clock period", per_err, 0);
        chk(edge_err == 0, "R2 changes on falling edge", edge_err, 0);
        total = (n_slots < 64) ? n_slots : 64;
        for (int i = 0; i < total; i++) begin
            if (i < 2) exp_w = 0;                       // R4 zero frame
            else if (i - 2 < nw) exp_w = int'(fq[8'(base + i - 2)] & m); // R3 R5
            else exp_w = 0;                             // R6 underrun
            chk(gw[i] == 32'(exp_w), (i < 2) ? "R4 zero frame" : ((i - 2 < nw) ? "R3 R5 slot data" : "R6 underrun zero"),
                gw[i], 32'(exp_w));
            chk(gl[i] == n, "R3 slot width", gl[i], n);
            chk(gc[i] == 1'(i % 2), "R2 channel order", gc[i], i % 2);
        end
        // R7: parked link
        quiet = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (bclk || ws || sd || fifo_ready) quiet = quiet + 1;
        end
        chk(quiet == 0, "R7 idle lines low", quiet, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail = n_fail + 1;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7731));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!bclk && !ws && !sd && !fifo_ready, "R8 in reset", {bclk, ws, sd, fifo_ready}, 0);
        @(posedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk(!bclk && !ws && !sd && !fifo_ready, "R8 after reset", {bclk, ws, sd, fifo_ready}, 0);
        // directed corners
        run_case(0, 32, 4, 1);   // 32-bit stereo
        run_case(2, 16, 6, 1);   // 16-bit stereo
        run_case(1, 0, 3, 1);    // R3 res 0 -> 32, odd count -> underrun
        run_case(0, 40, 2, 0);   // R3 above range -> 32
        run_case(3, 1, 5, 2);    // R3 res 1 -> 2
        run_case(0, 24, 0, 1);   // R6 empty FIFO from start
        // random mix
        for (int r = 0; r < 4; r++) begin
            run_case(int'($urandom_range(0, 4)), int'($urandom_range(2, 32)),
                     int'($urandom_range(0, 9)), int'($urandom_range(0, 1)));
        end
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule